// File: doc/BRIEF.md
# Interrupt Register Unit with Two-Deep Event Latching

This block gathers the raw event lines of one source unit and turns them into a single level interrupt toward an upstream collector. Each event line is watched for rising edges. An edge is recorded only when its enable bit is set. A recorded edge sets the matching bit of an identity register. Each bit can hold one further event behind the first, so software that clears a bit while a second event is waiting sees that bit return at once. The block drives a registered summary interrupt whenever any recorded bit is set and not masked.

Software reaches the unit through a plain 32-bit register port with a write strobe and a combinational read. The port has four word-aligned registers. A live status view shows the raw lines. A mask register blocks bits from the summary output. The identity register shows the recorded events and is cleared by writing ones. An enable register decides which edges are recorded. Writing all ones to the mask and zero to the enable shuts the unit off.

Top module: `irq_unit_regs`

## Requirements
- R1: After reset the mask reads all ones, the enable and identity registers read zero, and the interrupt output is low.
- R2: The byte offsets are 0x0 status, 0x4 mask, 0x8 identity and 0xC enable. The mask and enable registers read back the value last written. An access with either of the two low address bits set neither writes a register nor returns data (it reads as zero).
- R3: The status register shows the live level of every raw event line. Writes to it have no effect.
- R4: A rising edge on a raw line whose enable bit is set sets the matching identity bit at the clock edge where the line is first sampled high.
- R5: An edge that arrives while its enable bit is clear is dropped. Setting the enable bit later does not reveal it.
- R6: Writing a one to an identity bit clears it. Writing a zero to an identity bit leaves it unchanged.
- R7: Each identity bit holds up to two events. A clear while a second event is queued leaves the bit set, and a second clear then empties it. A third event that arrives while two are held is lost.
- R8: The interrupt output is the OR of all identity bits ANDed with the inverted mask. It is registered, so it follows the registers one clock later.
- R9: With the mask all ones and the enable zero, edges are not recorded and the interrupt output stays low.
- R10: A raw line held high for many cycles records a single event.
- R11: When a clear and a new edge for the same bit meet in one cycle, the bit ends up set and holds one event.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rawEvt | input | DATA_W | Raw event lines from the source unit |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Byte address of the access |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Combinational read data for regAddr |
| regRdata note | - | - | Misaligned addresses read zero |
| irqOut | output | 1 | Registered summary interrupt |

## Verification
The queued second event is hidden state. It is visible only when a clear leaves a bit set, so the stimulus pulses a single line two and three times before any clear and then clears repeatedly, reading the identity register after each clear. The hardest case is a clear and a fresh edge on the same bit in the same cycle. The bench drives the write strobe and the raw line together on one falling edge so both reach the same rising edge. It then shows, using only further clears, that exactly one event remains.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
  // byte address width of the register port: four words
  localparam int ADDR_W = 4;
  localparam int SEL_LSB = 2;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_IDENT  = 2'd2,
    SEL_ENABLE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic loadMask;
    logic loadEnable;
    logic clearIdent;
  } ctlStrobe_t;
endpackage

// File: rtl/irq_unit_ctl.sv
module irq_unit_ctl
  import irq_unit_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] statusVal,
  input  logic [DATA_W-1:0] maskVal,
  input  logic [DATA_W-1:0] identVal,
  input  logic [DATA_W-1:0] enableVal,
  output ctlStrobe_t        strobe,
  output logic [DATA_W-1:0] regRdata
);
  regSel_e sel;
  logic    aligned;

  assign sel     = regSel_e'(regAddr[SEL_LSB +: 2]);
  assign aligned = (regAddr[SEL_LSB-1:0] == '0);

  always_comb begin
    strobe            = '0;
    strobe.loadMask   = regWe && aligned && (sel == SEL_MASK);
    strobe.loadEnable = regWe && aligned && (sel == SEL_ENABLE);
    strobe.clearIdent = regWe && aligned && (sel == SEL_IDENT);
  end

  always_comb begin
    regRdata = '0;
    if (aligned) begin
      unique case (sel)
        SEL_STATUS: regRdata = statusVal;
        SEL_MASK:   regRdata = maskVal;
        SEL_IDENT:  regRdata = identVal;
        SEL_ENABLE: regRdata = enableVal;
        default:    regRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_unit_dp.sv
module irq_unit_dp
  import irq_unit_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] rawEvt,
  input  ctlStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] maskReg,
  output logic [DATA_W-1:0] enableReg,
  output logic [DATA_W-1:0] identReg,
  output logic [DATA_W-1:0] queuedReg,
  output logic              irqOut
);
  logic [DATA_W-1:0] rawPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawPrev   <= '0;
      maskReg   <= '1;
      enableReg <= '0;
      irqOut    <= 1'b0;
    end else begin
      rawPrev <= rawEvt;
      if (strobe.loadMask)   maskReg   <= wrData;
      if (strobe.loadEnable) enableReg <= wrData;
      irqOut <= |(identReg & ~maskReg);
    end
  end

  // one two-deep event cell per bit
  for (genvar i = 0; i < DATA_W; i++) begin : g_cell
    logic edgeHit, clrHit, idAfter, qAfter;

    always_comb begin
      edgeHit = rawEvt[i] & ~rawPrev[i] & enableReg[i];
      clrHit  = strobe.clearIdent & wrData[i];
      idAfter = identReg[i] & (~clrHit | queuedReg[i]);
      qAfter  = queuedReg[i] & ~clrHit;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        identReg[i]  <= 1'b0;
        queuedReg[i] <= 1'b0;
      end else begin
        identReg[i]  <= idAfter | edgeHit;
        queuedReg[i] <= qAfter | (edgeHit & idAfter);
      end
    end
  end
endmodule

// File: rtl/irq_unit_regs.sv
module irq_unit_regs
  import irq_unit_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] rawEvt,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqOut
);
  ctlStrobe_t        strobe;
  logic [DATA_W-1:0] maskVal, enableVal, identVal, queuedVal;

  irq_unit_ctl #(.DATA_W(DATA_W)) uCtl (
    .regWe     (regWe),
    .regAddr   (regAddr),
    .statusVal (rawEvt),
    .maskVal   (maskVal),
    .identVal  (identVal),
    .enableVal (enableVal),
    .strobe    (strobe),
    .regRdata  (regRdata)
  );

  irq_unit_dp #(.DATA_W(DATA_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .rawEvt    (rawEvt),
    .strobe    (strobe),
    .wrData    (regWdata),
    .maskReg   (maskVal),
    .enableReg (enableVal),
    .identReg  (identVal),
    .queuedReg (queuedVal),
    .irqOut    (irqOut)
  );
endmodule

// File: rtl/irq_unit_chk.sv
module irq_unit_chk
  import irq_unit_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] rawEvt,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic [DATA_W-1:0] regRdata,
  input logic              irqOut,
  input logic [DATA_W-1:0] maskVal,
  input logic [DATA_W-1:0] enableVal,
  input logic [DATA_W-1:0] identVal,
  input logic [DATA_W-1:0] queuedVal
);
  localparam logic [ADDR_W-1:0] OFS_IDENT = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 4'h0;

  // R3
  status_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == OFS_STATUS) |-> (regRdata == rawEvt));

  // R5
  no_disabled_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((identVal & ~$past(identVal) & ~$past(enableVal)) == '0));

  // R6
  clear_only_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWe && regAddr == OFS_IDENT) |=> (($past(identVal) & ~identVal) == '0));

  // R7
  queued_reappear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == OFS_IDENT && (regWdata & queuedVal) != '0) |=>
      ((identVal & $past(regWdata & queuedVal)) == $past(regWdata & queuedVal)));

  // R9
  full_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (&maskVal) |=> !irqOut);
endmodule

bind irq_unit_regs irq_unit_chk #(.DATA_W(DATA_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .rawEvt    (rawEvt),
  .regWe     (regWe),
  .regAddr   (regAddr),
  .regWdata  (regWdata),
  .regRdata  (regRdata),
  .irqOut    (irqOut),
  .maskVal   (maskVal),
  .enableVal (enableVal),
  .identVal  (identVal),
  .queuedVal (queuedVal)
);

// File: tb/irq_unit_regs_tb.sv
module irq_unit_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] rawEvt = '0;
  logic         regWe = 1'b0;
  logic [3:0]   regAddr = '0;
  logic [W-1:0] regWdata = '0;
  logic [W-1:0] regRdata;
  logic         irqOut;

  int total = 0;
  int fails = 0;
  bit finished = 0;

  typedef struct {
    bit           isIrq;
    logic [W-1:0] exp;
    string        tag;
  } item_t;
  item_t sbQ[$];
  event chkEv;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_unit_regs #(.DATA_W(W)) u_dut (
    .clk(clk), .rstN(rstN), .rawEvt(rawEvt), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut)
  );

  // monitor: pops expected items and compares
  initial begin
    forever begin
      @(chkEv);
      #1;
      while (sbQ.size() > 0) begin
        item_t it;
        logic [W-1:0] act;
        it = sbQ.pop_front();
        act = it.isIrq ? {{(W-1){1'b0}}, irqOut} : regRdata;
        total++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expRd(input logic [3:0] a, input logic [W-1:0] e, input string tag);
    @(negedge clk);
    regAddr = a;
    sbQ.push_back('{1'b0, e, tag});
    -> chkEv;
  endtask

  task automatic expIrq(input logic e, input string tag);
    @(negedge clk);
    sbQ.push_back('{1'b1, {{(W-1){1'b0}}, e}, tag});
    -> chkEv;
  endtask

  task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic pulse(input logic [W-1:0] b);
    @(negedge clk);
    rawEvt = b;
    @(negedge clk);
    rawEvt = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    expRd(4'h4, 32'hFFFF_FFFF, "R1 mask");
    expRd(4'hC, 32'h0, "R1 enable");
    expRd(4'h8, 32'h0, "R1 ident");
    expIrq(1'b0, "R1 irq");
    // R2 map
    wr(4'hC, 32'h0000_00FF);
    wr(4'h4, 32'hFFFF_FF00);
    expRd(4'hC, 32'h0000_00FF, "R2 enable readback");
    expRd(4'h4, 32'hFFFF_FF00, "R2 mask readback");
    wr(4'h5, 32'h0);
    expRd(4'h4, 32'hFFFF_FF00, "R2 misaligned write ignored");
    expRd(4'h6, 32'h0, "R2 misaligned read zero");
    // R3 live status, R10 held level
    @(negedge clk); rawEvt = 32'h0000_00A5;
    expRd(4'h0, 32'h0000_00A5, "R3 status live");
    wr(4'h0, 32'h1234_5678);
    expRd(4'h0, 32'h0000_00A5, "R3 status write ignored");
    repeat (5) @(negedge clk);
    rawEvt = '0;
    expRd(4'h8, 32'h0000_00A5, "R4 edges latched");
    expIrq(1'b1, "R8 irq raised");
    wr(4'h8, 32'h0000_00A5);
    expRd(4'h8, 32'h0, "R10 held level single event");
    expIrq(1'b0, "R8 irq dropped");
    // R5 disabled bit
    pulse(32'h0000_0100);
    expRd(4'h8, 32'h0, "R5 disabled dropped");
    wr(4'hC, 32'h0000_01FF);
    expRd(4'h8, 32'h0, "R5 not revealed");
    // R7 two deep
    pulse(32'h2); pulse(32'h2);
    expRd(4'h8, 32'h2, "R7 first");
    wr(4'h8, 32'h2);
    expRd(4'h8, 32'h2, "R7 reappear");
    wr(4'h8, 32'h2);
    expRd(4'h8, 32'h0, "R7 emptied");
    pulse(32'h2); pulse(32'h2); pulse(32'h2);
    wr(4'h8, 32'h2);
    wr(4'h8, 32'h2);
    expRd(4'h8, 32'h0, "R7 third lost");
    // R6 write zero no effect
    pulse(32'h8);
    wr(4'h8, 32'h0);
    expRd(4'h8, 32'h8, "R6 zero write");
    wr(4'h8, 32'hFFFF_FFF7);
    expRd(4'h8, 32'h8, "R6 other bits");
    wr(4'h8, 32'h8);
    expRd(4'h8, 32'h0, "R6 clear");
    // R8 masking
    wr(4'h4, 32'hFFFF_FF10);
    pulse(32'h10);
    expIrq(1'b0, "R8 masked");
    wr(4'h4, 32'hFFFF_FF00);
    expIrq(1'b1, "R8 unmasked");
    wr(4'h8, 32'h10);
    expIrq(1'b0, "R8 cleared");
    // R11 clear and edge together
    pulse(32'h40);
    @(negedge clk);
    regWe = 1'b1; regAddr = 4'h8; regWdata = 32'h40; rawEvt = 32'h40;
    @(negedge clk);
    regWe = 1'b0; rawEvt = '0;
    expRd(4'h8, 32'h40, "R11 still set");
    wr(4'h8, 32'h40);
    expRd(4'h8, 32'h0, "R11 single event");
    // R9 full disable
    wr(4'h4, 32'hFFFF_FFFF);
    wr(4'hC, 32'h0);
    pulse(32'hFF);
    expRd(4'h8, 32'h0, "R9 nothing latched");
    expIrq(1'b0, "R9 irq low");
    @(negedge clk);
    #2;
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule